// File: doc/BRIEF.md
# DDR SDRAM power-up command sequencer

This block drives the start-up command stream that a DDR SDRAM device needs before it can accept ordinary traffic. After a start pulse it waits for a fixed settling time. It then walks every populated rank in turn. For each rank it emits a fixed series of memory commands over a valid/ready command channel. Each command carries an operation code and a full memory address. The sequencer always adds the rank's base address to the command's own offset.

The mode-register value appears on the address lines. The sequencer builds it from the selected CAS latency and the burst-length-8 flag. Selected steps are followed by fixed quiet intervals, given as parameters in clock cycles. Each rank after the first takes its base from the previous rank's cumulative end register, which counts 32 MiB units.

When the mode load for the last rank has been accepted, the block raises `done` and holds it. The physical layer, the refresh scheduler and the data path belong to other blocks.

Top module: `ddr_init_seq`

## Requirements
- R1: While reset is held, `cmd_valid` and `done` are 0.
- R2: After `start` is sampled in the idle or done state with a non-zero rank count, `cmd_valid` stays low for exactly `T_PWR_CYC` cycles before the first command is offered.
- R3: Each rank receives, in this order: NOP at offset 0x1F000; precharge-all at 0x1F000; mode load at 0x2000; mode load at 0x800; precharge-all at 0x1F200; `REF_COUNT` refreshes at 0x1F300; and finally the main mode load. The operation codes are NOP=0, precharge-all=1, mode load=2 and refresh=3.
- R4: After each of the two mode loads at 0x2000 and 0x800 is accepted, `cmd_valid` is low for exactly `T_EXT_CYC` cycles.
- R5: After every refresh is accepted, `cmd_valid` is low for exactly `T_REF_CYC` cycles.
- R6: The offset of the final mode load is a 10-bit word, described here from the high bits to the low bits:
  - bits [9:7] hold the CAS code: 010 for CAS 2 (`cfg_cas`=01), 110 for CAS 2.5 (`cfg_cas`=10), and 011 for CAS 3 (`cfg_cas`=11 or 00);
  - bit [6] is 0, for sequential bursts;
  - bits [5:3] hold the burst length: 011 when `cfg_bl8`=1, else 010;
  - bits [2:0] are 0.
- R7: While `cmd_valid` is high and `cmd_ready` is low, the next cycle keeps `cmd_valid` high with `cmd_op` and `cmd_addr` unchanged.
- R8: `cmd_addr` = rank base + offset. Rank 0 has base 0. Rank r>0 has base = `cfg_rank_end` slice r-1 (8 bits at [8r-1:8r-8]) × 2^25.
- R9: Ranks 0 to `cfg_rank_cnt`-1 are served in order. `done` rises in the cycle after the last rank's final mode load is accepted. It then stays high with no further commands.
- R10: A `start` pulse while a sequence is in progress is ignored, and the command stream is unchanged.
- R11: A start with `cfg_rank_cnt`=0 raises `done` in the next cycle and issues no command.
- R12: Steps without a quiet interval are offered in the cycle right after the previous handshake, with no idle cycle. This applies to NOP, the precharges, and the step from a rank's last mode load to the next rank's NOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin the sequence (idle or done state only) |
| cfg_rank_cnt | input | RANK_W | Number of ranks to initialise |
| cfg_cas | input | 2 | CAS selection: 01=2, 10=2.5, other=3 |
| cfg_bl8 | input | 1 | Use burst length 8 instead of 4 |
| cfg_rank_end | input | NUM_RANKS*END_W | Cumulative rank end values, 32 MiB units |
| cmd_valid | output | 1 | Command offered |
| cmd_ready | input | 1 | Command accepted when high with valid |
| cmd_op | output | 2 | Operation code |
| cmd_addr | output | ADDR_W | Rank base plus command offset |
| done | output | 1 | All ranks initialised |

## Verification
Two events can fall in the same cycle.

The first is a rank's final mode-load handshake, which also switches the base to the next rank. The next rank's NOP must then appear one cycle later carrying the new base. Random back-pressure is used to stall that boundary. The bench judges it by the recorded address and by a zero idle-cycle count.

The second is a `start` pulse that lands while commands are pending. This is provoked mid-run. It is judged by requiring the full recorded stream, gaps included, to match the expected stream for one start.

// File: rtl/ddr_init_pkg.sv
package ddr_init_pkg;

    localparam int OFS_W = 17;

    typedef enum logic [1:0] {
        OP_NOP       = 2'd0,
        OP_PRECHARGE = 2'd1,
        OP_MODE_LOAD = 2'd2,
        OP_REFRESH   = 2'd3
    } ddr_op_e;

    typedef enum logic [1:0] {
        GAP_NONE,
        GAP_EXT,
        GAP_REF
    } gap_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT,
        ST_ISSUE,
        ST_DONE
    } seq_state_e;

    localparam logic [OFS_W-1:0] OFS_OPEN    = 17'h1F000;
    localparam logic [OFS_W-1:0] OFS_EXT_A   = 17'h02000;
    localparam logic [OFS_W-1:0] OFS_EXT_B   = 17'h00800;
    localparam logic [OFS_W-1:0] OFS_PRE2    = 17'h1F200;
    localparam logic [OFS_W-1:0] OFS_REFRESH = 17'h1F300;

endpackage

// File: rtl/ddr_init_timer.sv
module ddr_init_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - CNT_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);

    // R4/R5: quiet windows shrink by one per cycle until reloaded
    a_r4_timer_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

endmodule

// File: rtl/ddr_init_mode_word.sv
module ddr_init_mode_word
    import ddr_init_pkg::*;
(
    input  logic [1:0]       cas_code,
    input  logic             bl8,
    output logic [OFS_W-1:0] word
);

    logic [2:0] cas_f;
    logic [2:0] len_f;

    always_comb begin
        unique case (cas_code)
            2'b01:   cas_f = 3'b010;
            2'b10:   cas_f = 3'b110;
            default: cas_f = 3'b011;
        endcase
        len_f = bl8 ? 3'b011 : 3'b010;
        word  = OFS_W'({cas_f, 1'b0, len_f, 3'b000});
    end

endmodule

// File: rtl/ddr_init_step_dec.sv
module ddr_init_step_dec
    import ddr_init_pkg::*;
#(
    parameter int REF_COUNT = 8,
    parameter int STEP_W    = 4
) (
    input  logic [STEP_W-1:0] step,
    input  logic [OFS_W-1:0]  mode_word,
    output ddr_op_e           op,
    output logic [OFS_W-1:0]  ofs,
    output gap_kind_e         gap,
    output logic              last
);

    localparam int LAST_STEP = 5 + REF_COUNT;

    always_comb begin
        op   = OP_NOP;
        ofs  = OFS_OPEN;
        gap  = GAP_NONE;
        last = 1'b0;
        if (step == STEP_W'(0)) begin
            op = OP_NOP;
        end else if (step == STEP_W'(1)) begin
            op = OP_PRECHARGE;
        end else if (step == STEP_W'(2)) begin
            op  = OP_MODE_LOAD;
            ofs = OFS_EXT_A;
            gap = GAP_EXT;
        end else if (step == STEP_W'(3)) begin
            op  = OP_MODE_LOAD;
            ofs = OFS_EXT_B;
            gap = GAP_EXT;
        end else if (step == STEP_W'(4)) begin
            op  = OP_PRECHARGE;
            ofs = OFS_PRE2;
        end else if (step < STEP_W'(LAST_STEP)) begin
            op  = OP_REFRESH;
            ofs = OFS_REFRESH;
            gap = GAP_REF;
        end else begin
            op   = OP_MODE_LOAD;
            ofs  = mode_word;
            last = 1'b1;
        end
    end

endmodule

// File: rtl/ddr_init_seq.sv
module ddr_init_seq
    import ddr_init_pkg::*;
#(
    parameter int NUM_RANKS  = 4,
    parameter int END_W      = 8,
    parameter int RANK_SHIFT = 25,
    parameter int ADDR_W     = 36,
    parameter int REF_COUNT  = 8,
    parameter int T_PWR_CYC  = 50000,
    parameter int T_EXT_CYC  = 250,
    parameter int T_REF_CYC  = 25000,
    localparam int RANK_W    = $clog2(NUM_RANKS + 1)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start,
    input  logic [RANK_W-1:0]          cfg_rank_cnt,
    input  logic [1:0]                 cfg_cas,
    input  logic                       cfg_bl8,
    input  logic [NUM_RANKS*END_W-1:0] cfg_rank_end,
    output logic                       cmd_valid,
    input  logic                       cmd_ready,
    output logic [1:0]                 cmd_op,
    output logic [ADDR_W-1:0]          cmd_addr,
    output logic                       done
);

    localparam int IDX_W  = (NUM_RANKS > 1) ? $clog2(NUM_RANKS) : 1;
    localparam int STEP_N = 6 + REF_COUNT;
    localparam int STEP_W = $clog2(STEP_N);
    localparam int MAX_A  = (T_PWR_CYC > T_EXT_CYC) ? T_PWR_CYC : T_EXT_CYC;
    localparam int MAX_T  = (MAX_A > T_REF_CYC) ? MAX_A : T_REF_CYC;
    localparam int CNT_W  = (MAX_T > 1) ? $clog2(MAX_T + 1) : 1;

    typedef struct packed {
        seq_state_e          st;
        logic [STEP_W-1:0]   step;
        logic [RANK_W-1:0]   rank;
        logic [ADDR_W-1:0]   base;
    } seq_t;

    seq_t state_d, state_q;

    logic [END_W-1:0] rank_end [NUM_RANKS];

    for (genvar g = 0; g < NUM_RANKS; g++) begin : g_end
        assign rank_end[g] = cfg_rank_end[g*END_W +: END_W];
    end

    logic [OFS_W-1:0] mode_word;
    ddr_op_e          step_op;
    logic [OFS_W-1:0] step_ofs;
    gap_kind_e        step_gap;
    logic             step_last;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_expired;
    logic [CNT_W-1:0] gap_cyc;

    ddr_init_mode_word u_mode (
        .cas_code (cfg_cas),
        .bl8      (cfg_bl8),
        .word     (mode_word)
    );

    ddr_init_step_dec #(
        .REF_COUNT (REF_COUNT),
        .STEP_W    (STEP_W)
    ) u_dec (
        .step      (state_q.step),
        .mode_word (mode_word),
        .op        (step_op),
        .ofs       (step_ofs),
        .gap       (step_gap),
        .last      (step_last)
    );

    ddr_init_timer #(
        .CNT_W (CNT_W)
    ) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    always_comb begin
        unique case (step_gap)
            GAP_EXT: gap_cyc = CNT_W'(T_EXT_CYC);
            GAP_REF: gap_cyc = CNT_W'(T_REF_CYC);
            default: gap_cyc = '0;
        endcase
    end

    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state_q.st)
            ST_IDLE, ST_DONE: begin
                if (start) begin
                    if (cfg_rank_cnt == '0) begin
                        state_d.st = ST_DONE;
                    end else begin
                        state_d.rank = '0;
                        state_d.step = '0;
                        state_d.base = '0;
                        if (T_PWR_CYC == 0) begin
                            state_d.st = ST_ISSUE;
                        end else begin
                            state_d.st = ST_WAIT;
                            tmr_load   = 1'b1;
                            tmr_val    = CNT_W'(T_PWR_CYC - 1);
                        end
                    end
                end
            end
            ST_WAIT: begin
                if (tmr_expired) state_d.st = ST_ISSUE;
            end
            ST_ISSUE: begin
                if (cmd_ready) begin
                    if (step_last) begin
                        if ((state_q.rank + RANK_W'(1)) == cfg_rank_cnt) begin
                            state_d.st = ST_DONE;
                        end else begin
                            state_d.rank = state_q.rank + RANK_W'(1);
                            state_d.step = '0;
                            state_d.base = ADDR_W'(rank_end[state_q.rank[IDX_W-1:0]]) << RANK_SHIFT;
                        end
                    end else begin
                        state_d.step = state_q.step + STEP_W'(1);
                        if (gap_cyc != '0) begin
                            state_d.st = ST_WAIT;
                            tmr_load   = 1'b1;
                            tmr_val    = gap_cyc - CNT_W'(1);
                        end
                    end
                end
            end
            default: state_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q.st   <= ST_IDLE;
            state_q.step <= '0;
            state_q.rank <= '0;
            state_q.base <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign cmd_valid = (state_q.st == ST_ISSUE);
    assign cmd_op    = step_op;
    assign cmd_addr  = state_q.base + ADDR_W'(step_ofs);
    assign done      = (state_q.st == ST_DONE);

    // R7: an offered command is held until accepted
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_op) && $stable(cmd_addr)));

    // R9: nothing is offered once the sequence has completed
    a_r9_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !cmd_valid);

    // R9: commands only belong to configured ranks
    a_r9_rank_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (state_q.rank < cfg_rank_cnt));

    // R5: an accepted refresh is followed by a quiet cycle
    a_r5_ref_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ((T_REF_CYC > 0) && cmd_valid && cmd_ready && cmd_op == OP_REFRESH) |=> !cmd_valid);

    // R12: an accepted NOP is followed at once by the precharge
    a_r12_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && cmd_op == OP_NOP) |=> (cmd_valid && cmd_op == OP_PRECHARGE));

    // R10: a start pulse during a quiet window leaves position unchanged
    a_r10_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.st == ST_WAIT && start) |=> ($stable(state_q.step) && $stable(state_q.rank)));

endmodule

// File: tb/ddr_init_seq_tb.sv
`timescale 1ns/1ps
module ddr_init_seq_tb;

    localparam int NR    = 4;
    localparam int EW    = 8;
    localparam int AW    = 36;
    localparam int NREF  = 8;
    localparam int TPWR  = 20;
    localparam int TEXT  = 5;
    localparam int TREF  = 7;
    localparam int RW    = $clog2(NR + 1);

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start = 1'b0;
    logic [RW-1:0]  cfg_rank_cnt = '0;
    logic [1:0]     cfg_cas = 2'b01;
    logic           cfg_bl8 = 1'b0;
    logic [NR*EW-1:0] cfg_rank_end = {8'h20, 8'hFF, 8'h09, 8'h04};
    logic           cmd_valid;
    logic           cmd_ready = 1'b1;
    logic [1:0]     cmd_op;
    logic [AW-1:0]  cmd_addr;
    logic           done;

    always #2 clk = ~clk;

    ddr_init_seq #(
        .NUM_RANKS (NR), .END_W (EW), .RANK_SHIFT (25), .ADDR_W (AW),
        .REF_COUNT (NREF), .T_PWR_CYC (TPWR), .T_EXT_CYC (TEXT), .T_REF_CYC (TREF)
    ) u_dut (
        .clk (clk), .rst_n (rst_n), .start (start),
        .cfg_rank_cnt (cfg_rank_cnt), .cfg_cas (cfg_cas), .cfg_bl8 (cfg_bl8),
        .cfg_rank_end (cfg_rank_end), .cmd_valid (cmd_valid), .cmd_ready (cmd_ready),
        .cmd_op (cmd_op), .cmd_addr (cmd_addr), .done (done)
    );

    int n_chk = 0;
    int n_fail = 0;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // ready pattern
    int        rmode = 0;
    logic [15:0] lfsr = 16'hACE1;
    initial forever begin
        @(posedge clk);
        #1;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        cmd_ready = (rmode == 0) ? 1'b1 : lfsr[0];
    end

    // monitor, sampling at the falling edge
    int          cyc = 0;
    int          rec_n = 0;
    logic [1:0]  rec_op   [64];
    logic [AW-1:0] rec_addr [64];
    int          rec_gap  [64];
    int          rec_cyc  [64];
    int          idle = 0;
    bit          busy_pulse = 1'b0;
    bit          done_seen = 1'b0;
    int          done_cyc = 0;
    bit          hold_v = 1'b0;
    logic [1:0]  hold_op;
    logic [AW-1:0] hold_addr;

    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (hold_v)
                chk(cmd_valid && cmd_op == hold_op && cmd_addr == hold_addr,
                    "R7 stalled command changed", {26'd0, cmd_op, cmd_addr}, {26'd0, hold_op, hold_addr});
            hold_v    = cmd_valid && !cmd_ready;
            hold_op   = cmd_op;
            hold_addr = cmd_addr;
            if (start && !busy_pulse) begin
                idle = 0;
            end else if (cmd_valid && cmd_ready) begin
                if (rec_n < 64) begin
                    rec_op[rec_n]   = cmd_op;
                    rec_addr[rec_n] = cmd_addr;
                    rec_gap[rec_n]  = idle;
                    rec_cyc[rec_n]  = cyc;
                end
                rec_n++;
                idle = 0;
            end else if (!cmd_valid) begin
                idle++;
            end
            if (done && !done_seen) begin
                done_seen = 1'b1;
                done_cyc  = cyc;
            end
        end else begin
            hold_v = 1'b0;
        end
    end

    function automatic logic [16:0] exp_mode(input logic [1:0] cas, input bit bl8);
        logic [2:0] c;
        c = (cas == 2'b01) ? 3'b010 : (cas == 2'b10) ? 3'b110 : 3'b011;
        return {7'd0, c, 1'b0, (bl8 ? 3'b011 : 3'b010), 3'b000};
    endfunction

    task automatic do_reset();
        rst_n = 1'b0;
        start = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!cmd_valid, "R1 valid in reset", {63'd0, cmd_valid}, 64'd0);
        chk(!done, "R1 done in reset", {63'd0, done}, 64'd0);
        @(posedge clk);
        #1;
        rst_n = 1'b1;
        rec_n = 0;
        done_seen = 1'b0;
    endtask

    task automatic pulse_start();
        @(posedge clk);
        #1 start = 1'b1;
        @(posedge clk);
        #1 start = 1'b0;
    endtask

    // R11: zero ranks completes at once
    task automatic t_zero_ranks();
        do_reset();
        cfg_rank_cnt = '0;
        pulse_start();
        @(negedge clk);
        chk(done, "R11 done after zero-rank start", {63'd0, done}, 64'd1);
        repeat (5) @(negedge clk);
        chk(rec_n == 0, "R11 no commands for zero ranks", 64'(rec_n), 64'd0);
        chk(!cmd_valid, "R11 valid stays low", {63'd0, cmd_valid}, 64'd0);
    endtask

    // R2..R10, R12: full sequence with a given configuration
    task automatic t_run(input int ranks, input logic [1:0] cas, input bit bl8,
                         input int rm, input bit poke, input string name);
        logic [1:0]    eop  [64];
        logic [AW-1:0] eadr [64];
        int            egap [64];
        int            k = 0;
        int            prev_gap = TPWR;
        int            n_before;
        do_reset();
        cfg_rank_cnt = RW'(ranks);
        cfg_cas = cas;
        cfg_bl8 = bl8;
        rmode = rm;
        for (int r = 0; r < ranks; r++) begin
            logic [AW-1:0] base;
            base = (r == 0) ? '0 : (AW'(cfg_rank_end[(r-1)*EW +: EW]) << 25);
            for (int s = 0; s < 6 + NREF; s++) begin
                logic [1:0]  op;
                logic [16:0] ofs;
                int          g;
                g = 0;
                if (s == 0)            begin op = 2'd0; ofs = 17'h1F000; end
                else if (s == 1)       begin op = 2'd1; ofs = 17'h1F000; end
                else if (s == 2)       begin op = 2'd2; ofs = 17'h02000; g = TEXT; end
                else if (s == 3)       begin op = 2'd2; ofs = 17'h00800; g = TEXT; end
                else if (s == 4)       begin op = 2'd1; ofs = 17'h1F200; end
                else if (s < 5 + NREF) begin op = 2'd3; ofs = 17'h1F300; g = TREF; end
                else                   begin op = 2'd2; ofs = exp_mode(cas, bl8); end
                eop[k]  = op;
                eadr[k] = base + AW'(ofs);
                egap[k] = prev_gap;
                prev_gap = g;
                k++;
            end
        end
        pulse_start();
        if (poke) begin
            repeat (TPWR + 12) @(posedge clk);
            #1 busy_pulse = 1'b1; start = 1'b1;
            @(posedge clk);
            #1 start = 1'b0; busy_pulse = 1'b0;
        end
        for (int w = 0; w < 5000 && !done_seen; w++) @(negedge clk);
        chk(rec_n == k, {"R3/R9 command count ", name}, 64'(rec_n), 64'(k));
        for (int i = 0; i < k && i < rec_n; i++) begin
            chk(rec_op[i] == eop[i], {"R3 op ", name}, {62'd0, rec_op[i]}, {62'd0, eop[i]});
            chk(rec_addr[i] == eadr[i], {"R6/R8 addr ", name}, 64'(rec_addr[i]), 64'(eadr[i]));
            chk(rec_gap[i] == egap[i],
                (i == 0) ? {"R2 power wait ", name} : {"R4/R5/R12 gap ", name},
                64'(rec_gap[i]), 64'(egap[i]));
        end
        if (rec_n > 0)
            chk(done_cyc == rec_cyc[rec_n-1] + 1, {"R9 done timing ", name},
                64'(done_cyc), 64'(rec_cyc[rec_n-1] + 1));
        n_before = rec_n;
        repeat (10) @(negedge clk);
        chk(done && rec_n == n_before, {"R9 done holds quiet ", name}, 64'(rec_n), 64'(n_before));
        if (poke)
            chk(rec_n == k, "R10 start while busy ignored", 64'(rec_n), 64'(k));
    endtask

    initial begin
        #(4.0 * 190000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        t_zero_ranks();
        t_run(1, 2'b01, 1'b0, 0, 1'b0, "cl2 bl4 one rank");
        t_run(2, 2'b10, 1'b1, 1, 1'b1, "cl25 bl8 stalls poke");
        t_run(4, 2'b11, 1'b0, 1, 1'b0, "cl3 four ranks stalls");
        t_run(3, 2'b00, 1'b1, 0, 1'b0, "code0 cl3 bl8");
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule